// File: doc/BRIEF.md
# PHY Control-Register Bus Handshake Master

This block is the hardware side of a narrow register bus into a PHY. It accepts simple commands (read, write, or read-modify-write of one 16-bit register) and runs each one as a series of phases toward the PHY. An address phase captures the register address. A data phase captures the write value. A commit phase performs the write. A read phase returns the register contents. Every phase is a full four-phase request/acknowledge exchange. The value sits on the shared data bus for a fixed setup time before the phase strobe rises. The strobe stays high until the responder raises its acknowledge. The master then drops the strobe and waits for the acknowledge to fall.

Each acknowledge wait is bounded by a cycle counter that reloads whenever a wait begins. If any wait runs out, the whole command is abandoned and completion is reported with an error flag. A read-modify-write is a complete read followed by a complete write of the merged value to the same register. The value read is also returned to the requester. The command side is single-outstanding: a new command is taken only while the block is idle.

Top module: `crbus_master`

## Requirements
- R1: While reset is held, `cmd_ready` is 1, all four PHY strobes are 0, `phy_din` is 0, and `done` and `err` are 0.
- R2: A command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both 1. A `cmd_valid` pulse while busy has no effect on the PHY bus or on the result. `cmd_ready` is 0 from the cycle after acceptance until the completion cycle.
- R3: In every phase, `phy_din` carries the phase value for SETUP_CYC cycles (default 2) before the strobe rises. The strobe stays high until the edge at which `phy_ack` is sampled 1, and falls in the cycle after that edge. The phase ends at the first later edge where `phy_ack` is sampled 0. An address phase uses `phy_cap_addr` with the address on `phy_din`.
- R4: `cmd_op` = 2'b01 (write) runs an address phase, then a data phase with `phy_cap_data`, then a commit phase with `phy_write`. Both of the last two carry `cmd_wdata` on `phy_din`.
- R5: `cmd_op` = 2'b00 or 2'b11 (read) runs an address phase, then a read phase with `phy_din` = 0 and `phy_read` as strobe. `phy_dout` is latched at the edge where `phy_ack` is first sampled 1, and `rdata` shows it at completion.
- R6: `cmd_op` = 2'b10 (read-modify-write) runs a full read of `cmd_addr` and then a full write (address, data, commit) of `(old & ~cmd_mask) | cmd_wdata`. `rdata` returns the old value.
- R7: At most one of `phy_cap_addr`, `phy_cap_data`, `phy_write` and `phy_read` is 1 in any cycle.
- R8: Each wait for `phy_ack` high, and each wait for `phy_ack` low, may take at most TMO_CYC sampled edges; the limit applies afresh to every wait. If a wait exceeds it, the strobe drops, the remaining phases are skipped, and `done` and `err` pulse together.
- R9: `done` is a one-cycle pulse at the end of every accepted command. `err` is 0 on a successful command, and `cmd_ready` is 1 in the cycle of `done`.
- R10: `phy_din` does not change while any strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00/11 read, 01 write, 10 read-modify-write |
| cmd_addr | input | ADDR_W (16) | Register address |
| cmd_wdata | input | DATA_W (16) | Write value, or bits to set for read-modify-write |
| cmd_mask | input | DATA_W (16) | Bits cleared before merge (read-modify-write) |
| cmd_ready | output | 1 | Idle, command can be taken |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout abort, valid with done |
| rdata | output | DATA_W (16) | Last value read from the PHY |
| phy_din | output | DATA_W (16) | Shared address/data bus to the PHY |
| phy_cap_addr | output | 1 | Address capture strobe |
| phy_cap_data | output | 1 | Data capture strobe |
| phy_write | output | 1 | Write commit strobe |
| phy_read | output | 1 | Read strobe |
| phy_ack | input | 1 | Acknowledge from the PHY |
| phy_dout | input | DATA_W (16) | Read data from the PHY |

## Verification
A bench-side PHY responder stores registers and answers each strobe after a programmable delay. Fast single-cycle acknowledges and slow multi-cycle ones separate correct strobe release timing from an off-by-one hold. Reads of written and never-written registers, and read-modify-writes with partial and full masks, separate a correct merge from a plain overwrite or a stale read value. Acknowledge delays of exactly the limit and one past it, a responder that never releases acknowledge, and a command where every wait runs to the full limit separate a per-wait reloading timeout from a shared or off-by-one one. A command pulse issued mid-transaction shows whether a busy request leaks onto the bus.

// File: rtl/crbus_pkg.sv
`timescale 1ns/1ps
package crbus_pkg;
    typedef enum logic [1:0] {
        PH_ADDR   = 2'd0,
        PH_DATA   = 2'd1,
        PH_COMMIT = 2'd2,
        PH_READ   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_WRITE    = 2'd1,
        OP_RMW      = 2'd2,
        OP_READ_ALT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_SETUP,
        HS_HIGH,
        HS_LOW
    } hs_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT
    } sq_state_e;
endpackage

// File: rtl/crbus_wait_timer.sv
`timescale 1ns/1ps
module crbus_wait_timer #(
    parameter int unsigned LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(LIMIT - 1);
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/crbus_phase.sv
`timescale 1ns/1ps
module crbus_phase
    import crbus_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned TMO_CYC   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  phase_e            kind,
    input  logic [DATA_W-1:0] value,
    input  logic              ack,
    input  logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] din,
    output logic              cap_addr,
    output logic              cap_data,
    output logic              wr,
    output logic              rd,
    output logic              ok,
    output logic              fail,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned SW = $clog2(SETUP_CYC + 1);

    typedef struct packed {
        hs_state_e         st;
        phase_e            kind;
        logic [DATA_W-1:0] din;
        logic [SW-1:0]     scnt;
        logic [DATA_W-1:0] cap;
    } hs_regs_t;

    hs_regs_t r_d, r_q;
    logic     t_load, t_tick, expired;

    crbus_wait_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .tick    (t_tick),
        .expired (expired)
    );

    always_comb begin
        r_d    = r_q;
        ok     = 1'b0;
        fail   = 1'b0;
        t_load = 1'b0;
        t_tick = 1'b0;
        case (r_q.st)
            HS_IDLE: begin
                if (start) begin
                    r_d.st   = HS_SETUP;
                    r_d.kind = kind;
                    r_d.din  = (kind == PH_READ) ? '0 : value;
                    r_d.scnt = SW'(SETUP_CYC - 1);
                end
            end
            HS_SETUP: begin
                if (r_q.scnt == '0) begin
                    r_d.st = HS_HIGH;
                    t_load = 1'b1;
                end else begin
                    r_d.scnt = r_q.scnt - 1'b1;
                end
            end
            HS_HIGH: begin
                t_tick = 1'b1;
                if (ack) begin
                    t_load = 1'b1;
                    r_d.st = HS_LOW;
                    if (r_q.kind == PH_READ) r_d.cap = dout;
                end else if (expired) begin
                    fail   = 1'b1;
                    r_d.st = HS_IDLE;
                end
            end
            default: begin
                t_tick = 1'b1;
                if (!ack) begin
                    ok     = 1'b1;
                    r_d.st = HS_IDLE;
                end else if (expired) begin
                    fail   = 1'b1;
                    r_d.st = HS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    logic in_high;
    assign in_high  = (r_q.st == HS_HIGH);
    assign cap_addr = in_high && (r_q.kind == PH_ADDR);
    assign cap_data = in_high && (r_q.kind == PH_DATA);
    assign wr       = in_high && (r_q.kind == PH_COMMIT);
    assign rd       = in_high && (r_q.kind == PH_READ);
    assign din      = r_q.din;
    assign rd_data  = r_q.cap;

    logic strb_any;
    assign strb_any = cap_addr | cap_data | wr | rd;

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_addr, cap_data, wr, rd}));

    a_r3_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_any) |-> (($past(din) == din) && ($past(din, 2) == din)));

    a_r3_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_any && ack) |=> !strb_any);

    a_r10_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_any && $past(strb_any)) |-> $stable(din));

    a_r8_abort_drops_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (!strb_any && (r_q.st == HS_IDLE)));
endmodule

// File: rtl/crbus_seq.sv
`timescale 1ns/1ps
module crbus_seq
    import crbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] cmd_mask,
    output logic              cmd_ready,
    output logic              done,
    output logic              err,
    output logic              ph_start,
    output phase_e            ph_kind,
    output logic [DATA_W-1:0] ph_value,
    input  logic              ph_ok,
    input  logic              ph_fail,
    input  logic [DATA_W-1:0] ph_rdata
);
    typedef struct packed {
        sq_state_e         st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] mask;
        logic [2:0]        step;
        logic              done;
        logic              err;
    } sq_regs_t;

    sq_regs_t r_d, r_q;

    function automatic phase_e step_kind(input op_e op, input logic [2:0] s);
        phase_e k;
        if (op == OP_WRITE) begin
            case (s)
                3'd0:    k = PH_ADDR;
                3'd1:    k = PH_DATA;
                default: k = PH_COMMIT;
            endcase
        end else if (op == OP_RMW) begin
            case (s)
                3'd0:    k = PH_ADDR;
                3'd1:    k = PH_READ;
                3'd2:    k = PH_ADDR;
                3'd3:    k = PH_DATA;
                default: k = PH_COMMIT;
            endcase
        end else begin
            k = (s == 3'd0) ? PH_ADDR : PH_READ;
        end
        return k;
    endfunction

    function automatic logic [2:0] last_step(input op_e op);
        case (op)
            OP_WRITE: return 3'd2;
            OP_RMW:   return 3'd4;
            default:  return 3'd1;
        endcase
    endfunction

    logic [DATA_W-1:0] merged;
    assign merged  = (ph_rdata & ~r_q.mask) | r_q.wdata;
    assign ph_kind = step_kind(r_q.op, r_q.step);

    always_comb begin
        case (ph_kind)
            PH_ADDR: ph_value = DATA_W'(r_q.addr);
            PH_READ: ph_value = '0;
            default: ph_value = (r_q.op == OP_RMW) ? merged : r_q.wdata;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        ph_start = 1'b0;
        case (r_q.st)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    r_d.st    = SQ_LAUNCH;
                    r_d.op    = op_e'(cmd_op);
                    r_d.addr  = cmd_addr;
                    r_d.wdata = cmd_wdata;
                    r_d.mask  = cmd_mask;
                    r_d.step  = 3'd0;
                end
            end
            SQ_LAUNCH: begin
                ph_start = 1'b1;
                r_d.st   = SQ_WAIT;
            end
            default: begin
                if (ph_fail) begin
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.st   = SQ_IDLE;
                end else if (ph_ok) begin
                    if (r_q.step == last_step(r_q.op)) begin
                        r_d.done = 1'b1;
                        r_d.st   = SQ_IDLE;
                    end else begin
                        r_d.step = r_q.step + 3'd1;
                        r_d.st   = SQ_LAUNCH;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_ready = (r_q.st == SQ_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r9_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    a_r2_no_launch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !ph_start);
endmodule

// File: rtl/crbus_master.sv
`timescale 1ns/1ps
module crbus_master
    import crbus_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned TMO_CYC   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] cmd_mask,
    output logic              cmd_ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] phy_din,
    output logic              phy_cap_addr,
    output logic              phy_cap_data,
    output logic              phy_write,
    output logic              phy_read,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_dout
);
    logic              ph_start, ph_ok, ph_fail;
    phase_e            ph_kind;
    logic [DATA_W-1:0] ph_value, ph_rdata;

    crbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_mask  (cmd_mask),
        .cmd_ready (cmd_ready),
        .done      (done),
        .err       (err),
        .ph_start  (ph_start),
        .ph_kind   (ph_kind),
        .ph_value  (ph_value),
        .ph_ok     (ph_ok),
        .ph_fail   (ph_fail),
        .ph_rdata  (ph_rdata)
    );

    crbus_phase #(
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .TMO_CYC   (TMO_CYC)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ph_start),
        .kind     (ph_kind),
        .value    (ph_value),
        .ack      (phy_ack),
        .dout     (phy_dout),
        .din      (phy_din),
        .cap_addr (phy_cap_addr),
        .cap_data (phy_cap_data),
        .wr       (phy_write),
        .rd       (phy_read),
        .ok       (ph_ok),
        .fail     (ph_fail),
        .rd_data  (ph_rdata)
    );

    assign rdata = ph_rdata;
endmodule

// File: tb/crbus_master_bench.sv
`timescale 1ns/1ps
module crbus_master_bench;
    localparam int S = 2;
    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0, cmd_mask = '0;
    logic        cmd_ready, done, err;
    logic [15:0] rdata, phy_din;
    logic        phy_cap_addr, phy_cap_data, phy_write, phy_read;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_dout = 16'hDEAD;

    always #4 clk = ~clk;

    crbus_master #(.ADDR_W(16), .DATA_W(16), .SETUP_CYC(S), .TMO_CYC(T)) u_crbus_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
        .cmd_ready(cmd_ready), .done(done), .err(err), .rdata(rdata),
        .phy_din(phy_din), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_write(phy_write), .phy_read(phy_read), .phy_ack(phy_ack), .phy_dout(phy_dout)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    task automatic chk(input bit good, input string what, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (!good) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // PHY responder: register store with programmable acknowledge delays
    logic [15:0] mem [logic [15:0]];
    logic [15:0] r_addr = '0, r_data = '0;
    int dly_hi = 1, dly_lo = 1, hc = 0, lc = 0;
    bit stuck_lo = 0, stuck_hi = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!phy_ack) begin
                if (phy_cap_addr | phy_cap_data | phy_write | phy_read) begin
                    hc++;
                    if (hc >= dly_hi && !stuck_lo) begin
                        hc = 0;
                        phy_ack = 1'b1;
                        if (phy_cap_addr) r_addr = phy_din;
                        if (phy_cap_data) r_data = phy_din;
                        if (phy_write) mem[r_addr] = r_data;
                        if (phy_read) phy_dout = mem.exists(r_addr) ? mem[r_addr] : 16'h0000;
                    end
                end else hc = 0;
            end else begin
                if (!(phy_cap_addr | phy_cap_data | phy_write | phy_read)) begin
                    lc++;
                    if (lc >= dly_lo && !stuck_hi) begin
                        lc = 0;
                        phy_ack = 1'b0;
                    end
                end else lc = 0;
            end
        end
    end

    // Behavioural reference model: stage 0 idle, 1 launch, 2 setup, 3 ack-high wait, 4 ack-low wait
    int m_st = 0, m_idx = 0, m_cnt = 0, m_op = 0;
    int kinds[$];
    logic [15:0] m_addr, m_wd, m_mask, m_cap = '0, e_din = '0;
    bit e_done = 0, e_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cap = '0; e_din = '0; e_done = 0; e_err = 0;
        end else begin
            e_done = 0; e_err = 0;
            case (m_st)
                0: if (cmd_valid) begin
                    kinds.delete();
                    m_op = int'(cmd_op); m_addr = cmd_addr; m_wd = cmd_wdata; m_mask = cmd_mask;
                    if (m_op == 1) kinds = '{0, 1, 2};
                    else if (m_op == 2) kinds = '{0, 3, 0, 1, 2};
                    else kinds = '{0, 3};
                    m_idx = 0; m_st = 1;
                end
                1: begin
                    case (kinds[m_idx])
                        0: e_din = m_addr;
                        3: e_din = 16'h0000;
                        default: e_din = (m_op == 2) ? ((m_cap & ~m_mask) | m_wd) : m_wd;
                    endcase
                    m_cnt = S - 1; m_st = 2;
                end
                2: if (m_cnt == 0) begin m_st = 3; m_cnt = T - 1; end else m_cnt--;
                3: if (phy_ack) begin
                    if (kinds[m_idx] == 3) m_cap = phy_dout;
                    m_st = 4; m_cnt = T - 1;
                end else if (m_cnt == 0) begin
                    e_done = 1; e_err = 1; m_st = 0;
                end else m_cnt--;
                default: if (!phy_ack) begin
                    m_idx++;
                    if (m_idx == kinds.size()) begin e_done = 1; m_st = 0; end
                    else m_st = 1;
                end else if (m_cnt == 0) begin
                    e_done = 1; e_err = 1; m_st = 0;
                end else m_cnt--;
            endcase
        end
    end

    bit cmp_en = 0;
    always @(negedge clk) begin
        if (rst_n && cmp_en && !finished) begin
            logic [3:0] e_str, a_str;
            e_str = 4'b0000;
            if (m_st == 3) e_str[kinds[m_idx]] = 1'b1;
            a_str = {phy_read, phy_write, phy_cap_data, phy_cap_addr};
            chk(phy_din == e_din, "R3/R10 phy_din", phy_din, e_din);
            chk(a_str == e_str, "R7/R4 strobes {rd,wr,cd,ca}", 16'(a_str), 16'(e_str));
            chk(cmd_ready == (m_st == 0), "R2 cmd_ready", 16'(cmd_ready), 16'(m_st == 0));
            chk(done == e_done, "R9 done", 16'(done), 16'(e_done));
            chk(err == e_err, "R8 err", 16'(err), 16'(e_err));
            if (e_done && !e_err && (m_op != 1))
                chk(rdata == m_cap, "R5 rdata", rdata, m_cap);
        end
    end

    task automatic send(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd, input logic [15:0] mk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_mask = mk;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output bit e, output logic [15:0] rd);
        for (int i = 0; i < 5000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        e = err; rd = rdata;
    endtask

    task automatic run(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd,
                       input logic [15:0] mk, output bit e, output logic [15:0] rd);
        send(op, a, wd, mk);
        wait_done(e, rd);
    endtask

    function automatic logic [15:0] peek(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired act=%h exp=%h", 16'h0, 16'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        bit e;
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_ready == 1'b1, "R1 cmd_ready in reset", 16'(cmd_ready), 16'h1);
        chk({phy_cap_addr, phy_cap_data, phy_write, phy_read} == 4'b0, "R1 strobes in reset",
            16'({phy_cap_addr, phy_cap_data, phy_write, phy_read}), 16'h0);
        chk(phy_din == 16'h0, "R1 phy_din in reset", phy_din, 16'h0);
        chk({done, err} == 2'b00, "R1 done/err in reset", 16'({done, err}), 16'h0);
        rst_n = 1'b1;
        cmp_en = 1;

        // R4: write with fast acknowledge
        run(2'b01, 16'h1234, 16'hBEEF, 16'h0, e, rd);
        chk(e == 0, "R9 write err", 16'(e), 16'h0);
        chk(peek(16'h1234) == 16'hBEEF, "R4 write landed", peek(16'h1234), 16'hBEEF);

        // R5: read back, and read of an untouched register, using both read encodings
        run(2'b00, 16'h1234, 16'h0, 16'h0, e, rd);
        chk(rd == 16'hBEEF, "R5 read value", rd, 16'hBEEF);
        run(2'b11, 16'h0777, 16'hFFFF, 16'h0, e, rd);
        chk(rd == 16'h0000, "R5 read untouched", rd, 16'h0000);

        // R6: read-modify-write with slow acknowledge
        dly_hi = 3; dly_lo = 5;
        run(2'b01, 16'h0030, 16'h00A5, 16'h0, e, rd);
        run(2'b10, 16'h0030, 16'h0080, 16'h00F0, e, rd);
        chk(rd == 16'h00A5, "R6 rmw old value", rd, 16'h00A5);
        chk(peek(16'h0030) == 16'h0085, "R6 rmw merge", peek(16'h0030), 16'h0085);
        run(2'b10, 16'h0030, 16'h0000, 16'hFFFF, e, rd);
        chk(peek(16'h0030) == 16'h0000, "R6 rmw full mask", peek(16'h0030), 16'h0000);

        // R2: command pulse while busy is ignored
        dly_hi = 2; dly_lo = 2;
        send(2'b01, 16'h0001, 16'h1111, 16'h0);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 16'h0002; cmd_wdata = 16'h2222;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(e, rd);
        repeat (4) @(negedge clk);
        chk(peek(16'h0001) == 16'h1111, "R2 first command", peek(16'h0001), 16'h1111);
        chk(!mem.exists(16'h0002), "R2 busy command ignored", peek(16'h0002), 16'h0000);
        chk(cmd_ready == 1'b1, "R2 idle afterwards", 16'(cmd_ready), 16'h1);

        // R8: ack-high delay at the limit passes, one past aborts
        dly_hi = T; dly_lo = 1;
        run(2'b01, 16'h0040, 16'h5555, 16'h0, e, rd);
        chk(e == 0, "R8 delay at limit", 16'(e), 16'h0);
        chk(peek(16'h0040) == 16'h5555, "R8 write at limit", peek(16'h0040), 16'h5555);
        dly_hi = T + 1;
        run(2'b01, 16'h0041, 16'h7777, 16'h0, e, rd);
        chk(e == 1, "R8 delay past limit", 16'(e), 16'h1);
        chk(!mem.exists(16'h0041), "R8 aborted write", peek(16'h0041), 16'h0000);

        // R8: acknowledge never released
        dly_hi = 1; stuck_hi = 1;
        run(2'b00, 16'h1234, 16'h0, 16'h0, e, rd);
        chk(e == 1, "R8 ack stuck high", 16'(e), 16'h1);
        stuck_hi = 0;
        repeat (4) @(negedge clk);

        // R8: every wait at full length, counter reloads per wait
        dly_hi = T; dly_lo = T;
        run(2'b10, 16'h1234, 16'h0001, 16'h0F00, e, rd);
        chk(e == 0, "R8 reload per wait", 16'(e), 16'h0);
        chk(rd == 16'hBEEF, "R6 rmw slow old", rd, 16'hBEEF);
        chk(peek(16'h1234) == 16'hB0EF, "R6 rmw slow merge", peek(16'h1234), 16'hB0EF);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule